// File: doc/BRIEF.md
# Area-Decoded Static Memory Bus Controller

This block sits between a CPU-side request port and an external static memory bus. Each request carries a 32-bit address, a direction, an access size and write data. The controller looks at address bits 28..26 to pick a memory area, drives that area's chip select, and runs one bus cycle for SRAM or ROM. The cycle has an active-low read strobe that serves as output enable and four active-low per-byte write strobes. Two configuration fields per area set the width of the device's data bus and the number of wait states. A request that hits no supported area, or that is wider than the device bus, returns an error without touching the bus.

The sequencer is a three-state machine. ST_IDLE accepts a request. It goes to ST_PROG when the programmed wait count is nonzero and to ST_EXT when it is zero. On an error it stays in ST_IDLE and pulses the response. ST_PROG counts the programmed waits down and goes to ST_EXT after the last one. ST_EXT samples the active-low wait pin. It stays in ST_EXT while the pin is low and returns to ST_IDLE when the pin is high. On that last transition it raises the done pulse and returns the read data.

Top module: `sram_area_ctrl`

## Requirements
- R1: A request with address bits 28..26 equal to 3'b011 drives mem_cs3_n low, and 3'b100 drives mem_cs4_n low. The select stays low for every strobe cycle of that access. The two selects are never low together.
- R2: Address bits 31..29 have no effect on decoding, so each of the eight values of those bits reaches the same area. mem_addr carries request address bits 25..0.
- R3: A request whose bits 28..26 are neither 3'b011 nor 3'b100 asserts no select or strobe. It gives rsp_done=1 and rsp_err=1 in the cycle after acceptance.
- R4: The area-3 wait field value w (0..3) gives a bus cycle of exactly 1+w strobe cycles when mem_wait_n is high.
- R5: The area-4 wait field f gives w waits: w=f for f up to 4, and w=2f-4 above 4 (so 5→6, 6→8, 7→10). The bus cycle is then 1+w strobe cycles.
- R6: mem_wait_n is ignored during the programmed waits. Each cycle it is low after they end adds one strobe cycle.
- R7: A read holds mem_rd_n low and all mem_we_n high for the whole cycle. A write holds mem_rd_n high and drives the selected mem_we_n bits low.
- R8: Lane selection works as follows. Access size 00 is a byte, 01 a word, and 10 or 11 a longword. Width code 01 is a byte bus, 10 a word bus, and 11 or 00 a longword bus. The lanes are big-endian: mem_we_n[k] covers data bits 31-8k..24-8k, and a narrower device sits on the lowest lanes. The low address bits inside the bus width, aligned down to the access size, select the first lane.
- R9: Write data is taken right-aligned from req_wdata and placed on the selected lanes of mem_dout. Read data from those lanes of mem_din is returned right-aligned on rsp_rdata, with the upper bits zero. rsp_rdata is zero after a write.
- R10: An access wider than the width configured for its area asserts no strobe and completes as an error, in the same way as R3.
- R11: rsp_done pulses for one cycle, in the cycle after the last strobe cycle. req_ready is high only in ST_IDLE, and a req_valid raised while busy is ignored.
- R12: After reset, req_ready is high, all selects and strobes are high, and rsp_done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present; taken when req_ready is high |
| req_ready | output | 1 | Controller idle |
| req_addr | input | 32 | Request byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 00 byte, 01 word, 10/11 longword |
| req_wdata | input | 32 | Right-aligned write data |
| cfg_a3_width | input | 2 | Area-3 device bus width code |
| cfg_a3_wait | input | 2 | Area-3 wait field |
| cfg_a4_width | input | 2 | Area-4 device bus width code |
| cfg_a4_wait | input | 3 | Area-4 wait field |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | Completion was an error (with rsp_done) |
| rsp_rdata | output | 32 | Right-aligned read data |
| mem_cs3_n | output | 1 | Area-3 chip select, active low |
| mem_cs4_n | output | 1 | Area-4 chip select, active low |
| mem_rd_n | output | 1 | Read strobe / output enable, active low |
| mem_we_n | output | 4 | Per-lane write strobes, active low |
| mem_addr | output | 26 | Memory address |
| mem_dout | output | 32 | Write data to memory |
| mem_din | input | 32 | Read data from memory |
| mem_wait_n | input | 1 | External wait, active low |

## Verification
The hardest case to reach from the ports is the boundary between the programmed waits and the external wait: the wait pin must not act during ST_PROG, yet it must hold the cycle in ST_EXT. For each access the stimulus holds mem_wait_n low from the first strobe cycle and releases it only after the programmed waits plus a chosen number of extra cycles. A cycle length of exactly 1+waits+extra then shows that the pin is ignored while the count runs and honoured afterwards. A request raised in the middle of a long cycle, carrying an error address, shows that a busy controller ignores new requests.

// File: rtl/sac_pkg.sv
package sac_pkg;
    typedef enum logic [1:0] {
        AREA_NONE = 2'd0,
        AREA_3    = 2'd1,
        AREA_4    = 2'd2
    } area_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PROG = 2'd1,
        ST_EXT  = 2'd2
    } state_e;

    localparam logic [1:0] SZ_BYTE = 2'b00;
    localparam logic [1:0] SZ_WORD = 2'b01;
    localparam logic [1:0] BW_BYTE = 2'b01;
    localparam logic [1:0] BW_WORD = 2'b10;
endpackage

// File: rtl/sac_area_decode.sv
module sac_area_decode
    import sac_pkg::*;
#(
    parameter int AREA_W = 3,
    parameter logic [AREA_W-1:0] SEL_A3 = 3'b011,
    parameter logic [AREA_W-1:0] SEL_A4 = 3'b100
) (
    input  logic [AREA_W-1:0] area_field,
    output area_e             area
);
    always_comb begin
        if (area_field == SEL_A3)      area = AREA_3;
        else if (area_field == SEL_A4) area = AREA_4;
        else                           area = AREA_NONE;
    end
endmodule

// File: rtl/sac_wait_map.sv
module sac_wait_map #(
    parameter int FIELD_W    = 3,
    parameter int CNT_W      = 4,
    parameter int LINEAR_MAX = 4
) (
    input  logic [FIELD_W-1:0] field,
    output logic [CNT_W-1:0]   waits
);
    localparam logic [FIELD_W-1:0] LIN_F = FIELD_W'(LINEAR_MAX);
    localparam logic [CNT_W-1:0]   LIN_C = CNT_W'(LINEAR_MAX);

    // Linear up to LINEAR_MAX, then two cycles per step.
    always_comb begin
        if (field <= LIN_F) waits = CNT_W'(field);
        else                waits = CNT_W'({field, 1'b0}) - LIN_C;
    end
endmodule

// File: rtl/sac_lane_gen.sv
module sac_lane_gen
    import sac_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic [1:0]       width_code,
    input  logic [1:0]       size,
    input  logic [1:0]       addr_lo,
    output logic [LANES-1:0] lane_mask,
    output logic [1:0]       shift_bytes,
    output logic             too_wide
);
    logic [3:0] bus_b, acc_b, off, first, tail;

    always_comb begin
        unique case (width_code)
            BW_BYTE: bus_b = 4'd1;
            BW_WORD: bus_b = 4'd2;
            default: bus_b = 4'd4;
        endcase
        unique case (size)
            SZ_BYTE: acc_b = 4'd1;
            SZ_WORD: acc_b = 4'd2;
            default: acc_b = 4'd4;
        endcase
        too_wide = acc_b > bus_b;
        off      = {2'b00, addr_lo} & (bus_b - 4'd1) & ~(acc_b - 4'd1);
        first    = 4'd4 - bus_b + off;
        tail     = 4'd4 - first - acc_b;
        for (int k = 0; k < LANES; k++) begin
            lane_mask[k] = !too_wide && (4'(k) >= first) && (4'(k) < first + acc_b);
        end
        shift_bytes = too_wide ? 2'd0 : tail[1:0];
    end
endmodule

// File: rtl/sram_area_ctrl.sv
module sram_area_ctrl
    import sac_pkg::*;
#(
    parameter int MEM_ADDR_W = 26,
    parameter int AREA_W     = 3,
    parameter int A3_WAIT_W  = 2,
    parameter int A4_WAIT_W  = 3,
    parameter int A3_LIN_MAX = 3,
    parameter int A4_LIN_MAX = 4,
    parameter int CNT_W      = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    output logic                  req_ready,
    input  logic [31:0]           req_addr,
    input  logic                  req_write,
    input  logic [1:0]            req_size,
    input  logic [31:0]           req_wdata,
    input  logic [1:0]            cfg_a3_width,
    input  logic [A3_WAIT_W-1:0]  cfg_a3_wait,
    input  logic [1:0]            cfg_a4_width,
    input  logic [A4_WAIT_W-1:0]  cfg_a4_wait,
    output logic                  rsp_done,
    output logic                  rsp_err,
    output logic [31:0]           rsp_rdata,
    output logic                  mem_cs3_n,
    output logic                  mem_cs4_n,
    output logic                  mem_rd_n,
    output logic [3:0]            mem_we_n,
    output logic [MEM_ADDR_W-1:0] mem_addr,
    output logic [31:0]           mem_dout,
    input  logic [31:0]           mem_din,
    input  logic                  mem_wait_n
);
    localparam int LANES    = 4;
    localparam int AREA_LSB = MEM_ADDR_W;
    localparam int AREA_MSB = AREA_LSB + AREA_W - 1;

    // Bits above the area field are deliberately left out of decoding.
    logic unused_shadow_bits;
    assign unused_shadow_bits = ^req_addr[31:AREA_MSB+1];

    area_e            req_area;
    logic [CNT_W-1:0] a3_waits, a4_waits, req_waits;
    logic [1:0]       req_width;
    logic [LANES-1:0] req_mask;
    logic [1:0]       req_shift;
    logic             req_too_wide, req_bad;
    logic [31:0]      req_keep;

    sac_area_decode #(.AREA_W(AREA_W)) u_decode (
        .area_field (req_addr[AREA_MSB:AREA_LSB]),
        .area       (req_area)
    );

    sac_wait_map #(.FIELD_W(A3_WAIT_W), .CNT_W(CNT_W), .LINEAR_MAX(A3_LIN_MAX)) u_wait3 (
        .field (cfg_a3_wait),
        .waits (a3_waits)
    );

    sac_wait_map #(.FIELD_W(A4_WAIT_W), .CNT_W(CNT_W), .LINEAR_MAX(A4_LIN_MAX)) u_wait4 (
        .field (cfg_a4_wait),
        .waits (a4_waits)
    );

    assign req_width = (req_area == AREA_4) ? cfg_a4_width : cfg_a3_width;
    assign req_waits = (req_area == AREA_4) ? a4_waits : a3_waits;

    sac_lane_gen #(.LANES(LANES)) u_lanes (
        .width_code  (req_width),
        .size        (req_size),
        .addr_lo     (req_addr[1:0]),
        .lane_mask   (req_mask),
        .shift_bytes (req_shift),
        .too_wide    (req_too_wide)
    );

    always_comb begin
        unique case (req_size)
            SZ_BYTE: req_keep = 32'h0000_00FF;
            SZ_WORD: req_keep = 32'h0000_FFFF;
            default: req_keep = 32'hFFFF_FFFF;
        endcase
    end

    assign req_bad = (req_area == AREA_NONE) || req_too_wide;

    // Latched access
    state_e                state;
    logic [CNT_W-1:0]      cnt;
    area_e                 cur_area;
    logic                  cur_write;
    logic [LANES-1:0]      cur_mask;
    logic [1:0]            cur_shift;
    logic [31:0]           cur_keep;
    logic [MEM_ADDR_W-1:0] cur_addr;
    logic [31:0]           cur_wdata;
    logic [31:0]           rd_aligned;

    assign rd_aligned = (mem_din >> {cur_shift, 3'b000}) & cur_keep;

    // State register and latched request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            cnt       <= '0;
            cur_area  <= AREA_NONE;
            cur_write <= 1'b0;
            cur_mask  <= '0;
            cur_shift <= '0;
            cur_keep  <= '0;
            cur_addr  <= '0;
            cur_wdata <= '0;
            rsp_done  <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_done <= 1'b0;
            rsp_err  <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        if (req_bad) begin
                            rsp_done  <= 1'b1;
                            rsp_err   <= 1'b1;
                            rsp_rdata <= '0;
                        end else begin
                            cur_area  <= req_area;
                            cur_write <= req_write;
                            cur_mask  <= req_mask;
                            cur_shift <= req_shift;
                            cur_keep  <= req_keep;
                            cur_addr  <= req_addr[MEM_ADDR_W-1:0];
                            cur_wdata <= (req_wdata & req_keep) << {req_shift, 3'b000};
                            cnt       <= req_waits;
                            state     <= (req_waits == '0) ? ST_EXT : ST_PROG;
                        end
                    end
                end
                ST_PROG: begin
                    cnt <= cnt - 1'b1;
                    if (cnt == CNT_W'(1)) state <= ST_EXT;
                end
                ST_EXT: begin
                    if (mem_wait_n) begin
                        state     <= ST_IDLE;
                        rsp_done  <= 1'b1;
                        rsp_rdata <= cur_write ? 32'h0 : rd_aligned;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Bus outputs
    logic active;
    always_comb begin
        active    = (state != ST_IDLE);
        req_ready = (state == ST_IDLE);
        mem_cs3_n = !(active && cur_area == AREA_3);
        mem_cs4_n = !(active && cur_area == AREA_4);
        mem_rd_n  = !(active && !cur_write);
        mem_we_n  = (active && cur_write) ? ~cur_mask : 4'hF;
        mem_addr  = cur_addr;
        mem_dout  = cur_wdata;
    end

    // Assertions
    a_r7_rd_we_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_rd_n |-> (mem_we_n == 4'hF));

    a_r1_single_select: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_cs3_n && !mem_cs4_n));

    a_r10_we_needs_select: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we_n != 4'hF) |-> (!mem_cs3_n || !mem_cs4_n));

    a_r3_err_with_done: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_err |-> (rsp_done && mem_cs3_n && mem_cs4_n));

    a_r11_done_after_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_done && !rsp_err) |-> ($past(state == ST_EXT && mem_wait_n) && req_ready));

    a_r4_prog_count_live: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_PROG) |-> (cnt != '0));

    a_r6_addr_held: assert property (@(posedge clk) disable iff (!rst_n)
        (active && $past(state != ST_IDLE)) |-> $stable(mem_addr));
endmodule

// File: tb/sram_area_ctrl_test.sv
module sram_area_ctrl_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [1:0]  req_size = '0;
    logic [31:0] req_wdata = '0;
    logic [1:0]  cfg_a3_width = 2'b11;
    logic [1:0]  cfg_a3_wait = '0;
    logic [1:0]  cfg_a4_width = 2'b11;
    logic [2:0]  cfg_a4_wait = '0;
    logic        rsp_done, rsp_err;
    logic [31:0] rsp_rdata;
    logic        mem_cs3_n, mem_cs4_n, mem_rd_n;
    logic [3:0]  mem_we_n;
    logic [25:0] mem_addr;
    logic [31:0] mem_dout;
    logic [31:0] mem_din = '0;
    logic        mem_wait_n = 1'b1;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    sram_area_ctrl uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write), .req_size(req_size),
        .req_wdata(req_wdata), .cfg_a3_width(cfg_a3_width), .cfg_a3_wait(cfg_a3_wait),
        .cfg_a4_width(cfg_a4_width), .cfg_a4_wait(cfg_a4_wait), .rsp_done(rsp_done),
        .rsp_err(rsp_err), .rsp_rdata(rsp_rdata), .mem_cs3_n(mem_cs3_n),
        .mem_cs4_n(mem_cs4_n), .mem_rd_n(mem_rd_n), .mem_we_n(mem_we_n),
        .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_din(mem_din),
        .mem_wait_n(mem_wait_n)
    );

    task automatic chk(input bit ok, input string tag, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s got %h expected %h", tag, got, exp);
        end
    endtask

    // One access with expected values computed from the requirements.
    task automatic run_access(input logic [31:0] addr, input bit wr, input logic [1:0] size,
                              input logic [31:0] wd, input int extra, input bit intrude);
        bit is3, is4, bad, saw_done;
        int bus_b, acc_b, n, first, shift, strobes;
        logic [1:0]  wcode;
        logic [3:0]  exp_we;
        logic [31:0] keep, exp_rd, din;
        is3   = (addr[28:26] == 3'b011);
        is4   = (addr[28:26] == 3'b100);
        wcode = is4 ? cfg_a4_width : cfg_a3_width;
        bus_b = (wcode == 2'b01) ? 1 : (wcode == 2'b10) ? 2 : 4;
        acc_b = (size == 2'b00) ? 1 : (size == 2'b01) ? 2 : 4;
        bad   = !(is3 || is4) || (acc_b > bus_b);
        n     = is4 ? ((cfg_a4_wait <= 3'd4) ? int'(cfg_a4_wait) : 2 * int'(cfg_a4_wait) - 4)
                    : int'(cfg_a3_wait);
        first = 4 - bus_b + (int'(addr[1:0]) % bus_b) / acc_b * acc_b;
        shift = 4 - first - acc_b;
        keep  = (acc_b == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * acc_b)) - 1);
        exp_we = 4'hF;
        for (int k = 0; k < 4; k++) if (k >= first && k < first + acc_b) exp_we[k] = 1'b0;
        din    = 32'hA1B2_C3D4 ^ addr;
        exp_rd = (din >> (8 * shift)) & keep;

        @(negedge clk);
        req_addr = addr; req_write = wr; req_size = size; req_wdata = wd; req_valid = 1'b1;
        mem_din = din; mem_wait_n = 1'b0;
        @(negedge clk);
        req_valid = 1'b0;
        strobes = 0; saw_done = 1'b0;
        for (int it = 1; it <= 40; it++) begin
            if (!mem_cs3_n || !mem_cs4_n || !mem_rd_n || mem_we_n != 4'hF) begin
                strobes++;
                chk(mem_cs3_n == !is3 && mem_cs4_n == !is4, "R1 select", {mem_cs3_n, mem_cs4_n}, {!is3, !is4});
                chk(mem_rd_n == wr, "R7 read strobe", mem_rd_n, wr);
                chk(mem_we_n == (wr ? exp_we : 4'hF), "R8 lanes", mem_we_n, wr ? exp_we : 4'hF);
                chk(req_ready == 1'b0, "R11 busy", req_ready, 0);
                if (strobes == 1) begin
                    chk(mem_addr == addr[25:0], "R2 mem_addr", mem_addr, addr[25:0]);
                    if (wr) chk(mem_dout == ((wd & keep) << (8 * shift)), "R9 write data",
                                mem_dout, (wd & keep) << (8 * shift));
                end
                if (intrude) begin
                    req_valid = (strobes == 1);
                    req_addr  = 32'h1C00_0000;
                end
                mem_wait_n = (strobes >= n + extra + 1);
            end
            if (rsp_done) begin
                saw_done = 1'b1;
                break;
            end
            @(negedge clk);
        end
        mem_wait_n = 1'b1;
        chk(saw_done, "R11 done seen", saw_done, 1);
        chk(rsp_err == bad, bad ? "R3/R10 error flag" : "R3 no error", rsp_err, bad);
        if (bad) begin
            chk(strobes == 0, "R10 no strobes on error", strobes, 0);
        end else begin
            chk(strobes == n + extra + 1, is4 ? "R5/R6 cycle length" : "R4/R6 cycle length",
                strobes, n + extra + 1);
            chk(rsp_rdata == (wr ? 32'h0 : exp_rd), "R9 read data", rsp_rdata, wr ? 32'h0 : exp_rd);
        end
        @(negedge clk);
        chk(rsp_done == 1'b0, "R11 single pulse", rsp_done, 0);
        chk(mem_cs3_n && mem_cs4_n && req_ready, "R11 idle after done", {mem_cs3_n, mem_cs4_n, req_ready}, 3'b111);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(req_ready && mem_cs3_n && mem_cs4_n && mem_rd_n && mem_we_n == 4'hF && !rsp_done,
            "R12 reset state", {req_ready, mem_cs3_n, mem_cs4_n, mem_rd_n, mem_we_n, rsp_done}, 9'h1FE);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready && !rsp_done, "R12 after release", {req_ready, rsp_done}, 2'b10);

        // Area 3 sweep: waits x width x size x offset x direction (R4, R7, R8, R9, R10)
        for (int w = 0; w < 4; w++)
            for (int wc = 0; wc < 4; wc++)
                for (int sz = 0; sz < 4; sz++)
                    for (int lo = 0; lo < 4; lo++)
                        for (int d = 0; d < 2; d++) begin
                            cfg_a3_wait = 2'(w); cfg_a3_width = 2'(wc);
                            run_access(32'h0C00_1230 | 32'(lo), d[0], 2'(sz), 32'h5A6B_7C8D + 32'(lo), 0, 1'b0);
                        end

        // Area 4 wait map with external wait on top (R5, R6)
        cfg_a4_width = 2'b11;
        for (int f = 0; f < 8; f++)
            for (int e = 0; e < 3; e++) begin
                cfg_a4_wait = 3'(f);
                run_access(32'h1000_0040, f[0], 2'b10, 32'hCAFE_0000 + 32'(f), e, 1'b0);
            end

        // Shadow copies (R2)
        cfg_a3_width = 2'b11; cfg_a3_wait = 2'd1;
        for (int s = 0; s < 8; s++) begin
            run_access({3'(s), 3'b011, 26'h0ABCDE8}, 1'b0, 2'b10, 32'h0, 0, 1'b0);
            run_access({3'(s), 3'b100, 26'h1234560}, 1'b1, 2'b01, 32'h0000_BEEF, 1, 1'b0);
        end

        // Unsupported areas (R3)
        for (int a = 0; a < 8; a++)
            if (a != 3 && a != 4) begin
                run_access({3'b000, 3'(a), 26'h0000100}, a[0], 2'b10, 32'h1111_2222, 0, 1'b0);
            end

        // Request raised while busy is ignored (R11)
        cfg_a4_wait = 3'd7;
        run_access(32'h1000_0200, 1'b1, 2'b00, 32'h0000_00A5, 2, 1'b1);
        cfg_a3_wait = 2'd3; cfg_a3_width = 2'b10;
        run_access(32'h0C00_0302, 1'b0, 2'b00, 32'h0, 1, 1'b1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired got 0 expected 1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule